// File: doc/BRIEF.md
# Hash Core Register Front End

This block sits between a simple chip-select register bus and a hash engine that works on 512-bit message blocks and produces a 160-bit digest. Software loads sixteen 32-bit message words into a window of registers. It then writes a control word that sends a one-cycle start command to the engine. There are two commands: one begins a new message and the other continues the current message with a further block. Software polls a status word for the engine's ready and digest-valid indications and reads the digest back in five words. Three read-only identification words hold an ASCII name and an ASCII version.

Every access completes in one clock. A read presents its data on the cycle after chip select is sampled with write enable low. An access that the address map cannot honour raises an error flag for one cycle and changes no state. The error cases are a write to a read-only or unused address and a read from an unused address. Command generation is a small state machine with three states:

- `ST_IDLE` drives no command.
- `ST_INIT` drives the begin-message pulse.
- `ST_NEXT` drives the continue-message pulse.

From any state, the transitions are as follows:

- A control write with bit 0 set goes to `ST_INIT`.
- Otherwise, a control write with bit 1 set goes to `ST_NEXT`.
- Anything else goes to `ST_IDLE`.

The machine therefore never stays in a command state for two cycles unless a second control write arrives.

Top module: `hash_regfile`

## Requirements
- R1: While reset is low, and after it is released, `rdata`, `err`, `core_init`, `core_next`, every message word (so all of `core_block`) and the captured digest are zero.
- R2: Reads return identification words. Address 0x00 returns "hshr" (0x68736872) and 0x01 returns "egif" (0x65676966), with the first character in bits 31:24. Address 0x02 returns "0.10" (0x302e3130).
- R3: Read data appears on `rdata` in the cycle after `sel`=1 and `wr_en`=0 are sampled. In any cycle that does not follow such a read, `rdata` is zero.
- R4: A write to 0x08 with bit 0 set drives `core_init` high for exactly the next cycle. With bit 0 clear and bit 1 set, the write drives `core_next` high for exactly the next cycle. Bit 0 wins when both are set. The two outputs are never high together, and reading 0x08 returns zero.
- R5: Reading 0x09 returns `core_ready` in bit 0 and `core_digest_valid` in bit 1, as sampled in the read cycle. All other bits are zero.
- R6: A write to address 0x10+i (i = 0..15) stores the word at `core_block[511-32i -: 32]`. Reading the same address returns the stored word.
- R7: The digest register loads `core_digest` on every cycle that `core_digest_valid` is high and holds it otherwise. Reading 0x20+j (j = 0..4) returns bits `[159-32j -: 32]` of the held value.
- R8: `err` is high for exactly the cycle after any of these accesses: a write to 0x00–0x02, 0x09 or 0x20–0x24; a write or read of any address outside the map. Such an access changes no stored word, and the read data is zero.
- R9: With `sel` low, `wr_en`, `addr` and `wdata` have no effect: no word is stored, no command is issued, and `err` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Chip select for one access per cycle |
| wr_en | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after the read |
| err | output | 1 | One-cycle flag for a refused access |
| core_init | output | 1 | Begin-message pulse to the engine |
| core_next | output | 1 | Continue-message pulse to the engine |
| core_block | output | 512 | Message block to the engine |
| core_ready | input | 1 | Engine is idle |
| core_digest_valid | input | 1 | Engine digest is valid |
| core_digest | input | 160 | Engine digest |

## Verification
Message words are written with a distinct value per position, so a swapped or mis-indexed word shows up in `core_block` and on readback. Control writes use the values 1, 2 and 3, which separate the two commands and show the priority between them. Status reads cover the ready-only and ready-plus-valid combinations, so the two bit positions cannot be confused. The digest is loaded with one value and then changed while valid is low, which distinguishes capture-on-valid from a live pass-through. A set of refused accesses and deselected writes is followed by readbacks of the state those accesses could have touched.

// File: rtl/hreg_pkg.sv
package hreg_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    // Address map: positions are decoded by software, so they are fixed.
    localparam logic [ADDR_W-1:0] A_ID_HI  = 8'h00;
    localparam logic [ADDR_W-1:0] A_ID_LO  = 8'h01;
    localparam logic [ADDR_W-1:0] A_ID_VER = 8'h02;
    localparam logic [ADDR_W-1:0] A_CTRL   = 8'h08;
    localparam logic [ADDR_W-1:0] A_STAT   = 8'h09;
    localparam logic [ADDR_W-1:0] A_BLK    = 8'h10;
    localparam logic [ADDR_W-1:0] A_DIG    = 8'h20;

    localparam int CTRL_INIT_BIT = 0;
    localparam int CTRL_NEXT_BIT = 1;
    localparam int STAT_RDY_BIT  = 0;
    localparam int STAT_VAL_BIT  = 1;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_ID,
        RG_CTRL,
        RG_STATUS,
        RG_BLOCK,
        RG_DIGEST
    } region_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_INIT,
        ST_NEXT
    } cmd_state_t;
endpackage

// File: rtl/hreg_decode.sv
module hreg_decode
    import hreg_pkg::*;
#(
    parameter int N_WORDS   = 16,
    parameter int DIG_WORDS = 5,
    localparam int IDX_W    = (N_WORDS > 4) ? $clog2(N_WORDS) : 2
) (
    input  logic [ADDR_W-1:0] addr,
    output region_t           region,
    output logic [IDX_W-1:0]  idx,
    output logic              writable
);
    always_comb begin
        region = RG_NONE;
        idx    = '0;
        if (addr == A_ID_HI || addr == A_ID_LO || addr == A_ID_VER) begin
            region = RG_ID;
            idx    = IDX_W'(addr[1:0]);
        end else if (addr == A_CTRL) begin
            region = RG_CTRL;
        end else if (addr == A_STAT) begin
            region = RG_STATUS;
        end else if (int'(addr) >= int'(A_BLK) && int'(addr) < int'(A_BLK) + N_WORDS) begin
            region = RG_BLOCK;
            idx    = IDX_W'(int'(addr) - int'(A_BLK));
        end else if (int'(addr) >= int'(A_DIG) && int'(addr) < int'(A_DIG) + DIG_WORDS) begin
            region = RG_DIGEST;
            idx    = IDX_W'(int'(addr) - int'(A_DIG));
        end
    end

    assign writable = (region == RG_CTRL) || (region == RG_BLOCK);
endmodule

// File: rtl/hreg_cmd_fsm.sv
module hreg_cmd_fsm
    import hreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic want_init,
    input  logic want_next,
    output logic pulse_init,
    output logic pulse_next
);
    cmd_state_t state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: every state leaves after one cycle unless re-commanded
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_INIT, ST_NEXT: begin
                if (ctrl_wr && want_init)      state_d = ST_INIT;
                else if (ctrl_wr && want_next) state_d = ST_NEXT;
                else                           state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        pulse_init = 1'b0;
        pulse_next = 1'b0;
        unique case (state_q)
            ST_INIT: pulse_init = 1'b1;
            ST_NEXT: pulse_next = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/hreg_block_store.sv
module hreg_block_store
    import hreg_pkg::*;
#(
    parameter int N_WORDS  = 16,
    localparam int IDX_W   = (N_WORDS > 4) ? $clog2(N_WORDS) : 2,
    localparam int BLK_W   = N_WORDS * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [BLK_W-1:0]  block,
    output logic [DATA_W-1:0] rd_word
);
    // Word 0 lands in the most significant slice of the block.
    for (genvar i = 0; i < N_WORDS; i++) begin : g_word
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          q <= '0;
            else if (wr && idx == IDX_W'(i))     q <= wdata;
        end
        assign block[BLK_W-1-i*DATA_W -: DATA_W] = q;
    end

    always_comb begin
        rd_word = '0;
        for (int k = 0; k < N_WORDS; k++) begin
            if (idx == IDX_W'(k)) rd_word = block[BLK_W-1-k*DATA_W -: DATA_W];
        end
    end
endmodule

// File: rtl/hreg_digest_cap.sv
module hreg_digest_cap
    import hreg_pkg::*;
#(
    parameter int DIG_WORDS = 5,
    parameter int IDX_W     = 4,
    localparam int DIG_W    = DIG_WORDS * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [DIG_W-1:0]  digest,
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] rd_word
);
    logic [DIG_W-1:0] dig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     dig_q <= '0;
        else if (valid) dig_q <= digest;
    end

    always_comb begin
        rd_word = '0;
        for (int j = 0; j < DIG_WORDS; j++) begin
            if (idx == IDX_W'(j)) rd_word = dig_q[DIG_W-1-j*DATA_W -: DATA_W];
        end
    end
endmodule

// File: rtl/hash_regfile.sv
module hash_regfile
    import hreg_pkg::*;
#(
    parameter int          N_WORDS   = 16,
    parameter int          DIG_WORDS = 5,
    parameter logic [31:0] ID_HI     = 32'h68736872,
    parameter logic [31:0] ID_LO     = 32'h65676966,
    parameter logic [31:0] ID_VER    = 32'h302e3130
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sel,
    input  logic                        wr_en,
    input  logic [7:0]                  addr,
    input  logic [31:0]                 wdata,
    output logic [31:0]                 rdata,
    output logic                        err,
    output logic                        core_init,
    output logic                        core_next,
    output logic [N_WORDS*32-1:0]       core_block,
    input  logic                        core_ready,
    input  logic                        core_digest_valid,
    input  logic [DIG_WORDS*32-1:0]     core_digest
);
    localparam int IDX_W = (N_WORDS > 4) ? $clog2(N_WORDS) : 2;

    region_t           region;
    logic [IDX_W-1:0]  idx;
    logic              writable;
    logic              acc_rd, acc_wr, refused;
    logic [DATA_W-1:0] blk_word, dig_word, rd_val;
    logic [DATA_W-1:0] rdata_q;
    logic              err_q;

    hreg_decode #(.N_WORDS(N_WORDS), .DIG_WORDS(DIG_WORDS)) u_dec (
        .addr     (addr),
        .region   (region),
        .idx      (idx),
        .writable (writable)
    );

    assign acc_rd  = sel && !wr_en;
    assign acc_wr  = sel && wr_en;
    assign refused = (acc_wr && !writable) || (acc_rd && region == RG_NONE);

    hreg_cmd_fsm u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (acc_wr && region == RG_CTRL),
        .want_init  (wdata[CTRL_INIT_BIT]),
        .want_next  (wdata[CTRL_NEXT_BIT]),
        .pulse_init (core_init),
        .pulse_next (core_next)
    );

    hreg_block_store #(.N_WORDS(N_WORDS)) u_blk (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (acc_wr && region == RG_BLOCK),
        .idx     (idx),
        .wdata   (wdata),
        .block   (core_block),
        .rd_word (blk_word)
    );

    hreg_digest_cap #(.DIG_WORDS(DIG_WORDS), .IDX_W(IDX_W)) u_dig (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (core_digest_valid),
        .digest  (core_digest),
        .idx     (idx),
        .rd_word (dig_word)
    );

    always_comb begin
        rd_val = '0;
        unique case (region)
            RG_ID: begin
                if (idx == IDX_W'(0))      rd_val = ID_HI;
                else if (idx == IDX_W'(1)) rd_val = ID_LO;
                else                       rd_val = ID_VER;
            end
            RG_STATUS: begin
                rd_val[STAT_RDY_BIT] = core_ready;
                rd_val[STAT_VAL_BIT] = core_digest_valid;
            end
            RG_BLOCK:  rd_val = blk_word;
            RG_DIGEST: rd_val = dig_word;
            RG_CTRL, RG_NONE: rd_val = '0;
            default:   rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            rdata_q <= acc_rd ? rd_val : '0;
            err_q   <= refused;
        end
    end

    assign rdata = rdata_q;
    assign err   = err_q;
endmodule

// File: rtl/hreg_checker.sv
module hreg_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        sel,
    input logic        wr_en,
    input logic [7:0]  addr,
    input logic [31:0] wdata,
    input logic [31:0] rdata,
    input logic        err,
    input logic        core_init,
    input logic        core_next
);
    // R4
    cmd_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_init && core_next));

    // R4
    init_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_init |-> $past(sel && wr_en && addr == 8'h08 && wdata[0]));

    // R4
    next_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_next |-> $past(sel && wr_en && addr == 8'h08 && !wdata[0] && wdata[1]));

    // R8
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(sel));

    // R3
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sel && !wr_en) |-> rdata == 32'd0);

    // R9
    quiet_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sel) |-> !err && !core_init && !core_next);
endmodule

bind hash_regfile hreg_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .err       (err),
    .core_init (core_init),
    .core_next (core_next)
);

// File: tb/tb_hash_regfile.sv
module tb_hash_regfile;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sel = 1'b0, wr_en = 1'b0;
    logic [7:0]   addr = 8'h00;
    logic [31:0]  wdata = 32'h0;
    logic [31:0]  rdata;
    logic         err, core_init, core_next;
    logic [511:0] core_block;
    logic         core_ready = 1'b0, core_digest_valid = 1'b0;
    logic [159:0] core_digest = '0;

    int checks = 0, failures = 0;
    bit done = 0;

    always #10 clk = ~clk; // 50 MHz

    hash_regfile dut (.*);

    // ---------------- behavioural reference model ----------------
    logic [31:0]  m_blk [16];
    logic [159:0] m_dig;
    logic [31:0]  e_rdata;
    logic         e_err, e_init, e_next;

    function automatic bit in_map(input logic [7:0] a);
        return (a <= 8'h02) || a == 8'h08 || a == 8'h09 ||
               (a >= 8'h10 && a <= 8'h1f) || (a >= 8'h20 && a <= 8'h24);
    endfunction

    function automatic bit can_write(input logic [7:0] a);
        return a == 8'h08 || (a >= 8'h10 && a <= 8'h1f);
    endfunction

    function automatic logic [31:0] ref_read(input logic [7:0] a);
        if (a == 8'h00) return "hshr";
        if (a == 8'h01) return "egif";
        if (a == 8'h02) return "0.10";
        if (a == 8'h09) return {30'd0, core_digest_valid, core_ready};
        if (a >= 8'h10 && a <= 8'h1f) return m_blk[a - 8'h10];
        if (a >= 8'h20 && a <= 8'h24) return m_dig[159 - 32*(a - 8'h20) -: 32];
        return 32'd0;
    endfunction

    function automatic logic [511:0] ref_block();
        logic [511:0] b;
        for (int i = 0; i < 16; i++) b[511 - 32*i -: 32] = m_blk[i];
        return b;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) m_blk[i] <= 32'd0;
            m_dig <= '0; e_rdata <= 32'd0; e_err <= 1'b0; e_init <= 1'b0; e_next <= 1'b0;
        end else begin
            e_init  <= sel && wr_en && addr == 8'h08 && wdata[0];
            e_next  <= sel && wr_en && addr == 8'h08 && !wdata[0] && wdata[1];
            e_err   <= sel && (wr_en ? !can_write(addr) : !in_map(addr));
            e_rdata <= (sel && !wr_en) ? ref_read(addr) : 32'd0;
            if (sel && wr_en && addr >= 8'h10 && addr <= 8'h1f) m_blk[addr - 8'h10] <= wdata;
            if (core_digest_valid) m_dig <= core_digest;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) if (rst_n && !done) begin
        chk(rdata == e_rdata, "R3 rdata vs model", 512'(rdata), 512'(e_rdata));
        chk(err == e_err, "R8 err vs model", 512'(err), 512'(e_err));
        chk(core_init == e_init, "R4 init vs model", 512'(core_init), 512'(e_init));
        chk(core_next == e_next, "R4 next vs model", 512'(core_next), 512'(e_next));
        chk(core_block == ref_block(), "R6 block vs model", core_block, ref_block());
    end

    // ---------------- bus tasks ----------------
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); sel = 1; wr_en = 1; addr = a; wdata = d;
        @(negedge clk); sel = 0; wr_en = 0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d, output logic e);
        @(negedge clk); sel = 1; wr_en = 0; addr = a;
        @(negedge clk); sel = 0; d = rdata; e = err;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0]  d;
        logic         e;
        logic [159:0] dg;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(rdata == 0 && err == 0 && core_init == 0 && core_next == 0,
            "R1 outputs in reset", 512'({rdata, err, core_init, core_next}), 512'(0));
        chk(core_block == 0, "R1 block in reset", core_block, 512'(0));
        rst_n = 1;
        bus_read(8'h20, d, e);
        chk(d == 0, "R1 digest after reset", 512'(d), 512'(0));

        // R2 identification
        bus_read(8'h00, d, e); chk(d == 32'h68736872, "R2 id hi", 512'(d), 512'h68736872);
        bus_read(8'h01, d, e); chk(d == 32'h65676966, "R2 id lo", 512'(d), 512'h65676966);
        bus_read(8'h02, d, e); chk(d == 32'h302e3130, "R2 version", 512'(d), 512'h302e3130);

        // R3 idle cycle after a read returns zero
        @(negedge clk); chk(rdata == 0, "R3 idle rdata", 512'(rdata), 512'(0));

        // R6 message words
        for (int i = 0; i < 16; i++) bus_write(8'h10 + 8'(i), 32'hA5000000 + 32'(i * 32'h00010101));
        chk(core_block[511:480] == 32'hA5000000, "R6 word0 msb slice", 512'(core_block[511:480]), 512'hA5000000);
        chk(core_block[31:0] == 32'hA50F0F0F, "R6 word15 lsb slice", 512'(core_block[31:0]), 512'hA50F0F0F);
        bus_read(8'h13, d, e); chk(d == 32'hA5030303, "R6 readback", 512'(d), 512'hA5030303);

        // R4 commands
        bus_write(8'h08, 32'h1);
        chk(core_init == 1 && core_next == 0, "R4 init pulse", 512'({core_init, core_next}), 512'h2);
        @(negedge clk); chk(core_init == 0, "R4 init one cycle", 512'(core_init), 512'(0));
        bus_write(8'h08, 32'h2);
        chk(core_next == 1 && core_init == 0, "R4 next pulse", 512'({core_init, core_next}), 512'h1);
        bus_write(8'h08, 32'h3);
        chk(core_init == 1 && core_next == 0, "R4 init priority", 512'({core_init, core_next}), 512'h2);
        bus_read(8'h08, d, e); chk(d == 0 && e == 0, "R4 ctrl reads zero", 512'({d, e}), 512'(0));

        // R5 status
        core_ready = 1; core_digest_valid = 0;
        bus_read(8'h09, d, e); chk(d == 32'h1, "R5 ready only", 512'(d), 512'h1);

        // R7 digest capture then hold
        dg = 160'h0123456789abcdef_fedcba98_76543210_a1b2c3d4;
        @(negedge clk); core_digest = dg; core_digest_valid = 1;
        bus_read(8'h09, d, e); chk(d == 32'h3, "R5 ready and valid", 512'(d), 512'h3);
        core_digest_valid = 0; core_digest = ~dg;
        for (int j = 0; j < 5; j++) begin
            bus_read(8'h20 + 8'(j), d, e);
            chk(d == dg[159 - 32*j -: 32], "R7 digest word", 512'(d), 512'(dg[159 - 32*j -: 32]));
        end

        // R8 refused accesses
        bus_write(8'h09, 32'hFFFF_FFFF);
        chk(err == 1, "R8 write status", 512'(err), 512'(1));
        @(negedge clk); chk(err == 0, "R8 err one cycle", 512'(err), 512'(0));
        bus_write(8'h21, 32'h0);
        bus_read(8'h21, d, e);
        chk(d == dg[127:96] && e == 0, "R8 digest unchanged", 512'(d), 512'(dg[127:96]));
        bus_read(8'h05, d, e);
        chk(d == 0 && e == 1, "R8 unmapped read", 512'({d, e}), 512'(1));
        bus_write(8'h40, 32'h1234);
        chk(err == 1, "R8 unmapped write", 512'(err), 512'(1));

        // R9 deselected write
        @(negedge clk); sel = 0; wr_en = 1; addr = 8'h10; wdata = 32'hDEAD0000;
        @(negedge clk); wr_en = 0;
        chk(core_block[511:480] == 32'hA5000000 && err == 0, "R9 deselected write",
            512'(core_block[511:480]), 512'hA5000000);
        @(negedge clk); sel = 0; wr_en = 1; addr = 8'h08; wdata = 32'h1;
        @(negedge clk); wr_en = 0;
        chk(core_init == 0, "R9 no command when deselected", 512'(core_init), 512'(0));

        repeat (2) @(negedge clk);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule